// File: doc/BRIEF.md
# Serial Register-Access Slave Port

This block lets an external controller read and write a small bank of byte-wide registers over a chip-select, serial-clock and data-line link. The controller lowers chip-select and sends an 8-bit command byte. The command byte carries a direction flag, a two-bit byte count and a five-bit register address. One or more data bytes follow. Write data is taken in on rising serial-clock edges. Read data is put out on falling edges, so the controller can capture it on the following rising edge.

Register 0 is the port's own control register. One bit of it reverses the bit order of every byte, command and data alike. Another bit moves read data from the shared data pin to a separate output pin. The serial inputs are resampled by the system clock through a short synchronizer, and all state lives in that clock domain. The pins are modelled as a value plus an output enable, so the chip pad ring builds the actual tri-state drivers.

The control FSM has five states. IDLE waits for chip-select. HDR collects the command byte. WR takes in write bytes. RD shifts out read bytes. DONE ignores further clocks until chip-select rises. The transitions are:
- IDLE to HDR when chip-select is seen active.
- HDR to WR or RD on the eighth rising edge, chosen by the direction flag.
- WR or RD to DONE at the end of the last counted byte.
- Any state to IDLE when chip-select goes inactive.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, all registers read 0. The port starts MSB-first in 3-wire mode, with `sdio_oe` and `sdo_oe` both low.
- R2: In MSB-first order the command byte is {rw, len[1:0], addr[4:0]} and is sent bit 7 first. Its bits are sampled on the first eight rising `sclk` edges after `cs_n` falls.
- R3: With rw = 0, each following group of eight rising edges supplies one data byte. Each byte is written to the current address once its eighth bit arrives.
- R4: With rw = 1, the addressed register's bits change on falling `sclk` edges. Each bit is valid at the next rising edge, starting with the first edge after the command byte. In MSB-first order bit 7 comes first.
- R5: The len field gives len+1 data bytes (0 gives 1 byte, 3 gives 4 bytes). After each byte the address steps by +1 in MSB-first order and by -1 in LSB-first order, wrapping modulo 32.
- R6: Register 0 bit 6 set selects LSB-first order. Every command and data byte is then sent bit 0 first, so addr[0] leads and rw comes last. A change to this bit first affects the byte after the one that wrote it.
- R7: Register 0 bit 3 set selects 4-wire mode. Read data then appears on `sdo_out` with `sdo_oe` high, and `sdio_oe` stays low throughout. With bit 3 clear, read data appears on `sdio_out` with `sdio_oe` high, and `sdo_oe` stays low.
- R8: An output enable is high only while read data bytes are being shifted out. It is low during the command byte, during writes, and after the last counted byte.
- R9: Raising `cs_n` at any point ends the transfer. It drops both enables and discards a partly shifted byte, so no write occurs. The next transfer starts with a fresh command byte.
- R10: Register 0 reads back only bits 6 and 3, with all other bits 0. Addresses 1 to NUM_REGS-1 hold full bytes. Addresses at or above NUM_REGS read 0 and ignore writes.
- R11: Clock edges after the last counted byte cause no write and drive no output until `cs_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, idle low |
| sdio_in | input | 1 | Value received on the shared data pin |
| sdio_out | output | 1 | Value driven on the shared data pin |
| sdio_oe | output | 1 | Drive enable for the shared data pin |
| sdo_out | output | 1 | Value on the separate read-data pin |
| sdo_oe | output | 1 | Drive enable for the separate read-data pin |

## Verification
The bench sweeps all four combinations of bit order and wire mode. In each combination it runs writes and read-backs over every start address from 1 to 9 and every length from 1 to 4 bytes, with data bytes derived arithmetically from address, length and position. This separates the effects of address stepping direction, byte counting and bit reversal. Bursts that run past the last implemented register show that out-of-range writes are dropped. Reads of register 0 show the masking of its unused bits, and a burst that wraps from address 31 to 0 exercises the modulo step. A write cut short by chip-select, a read cut short in the same way, and a write followed by extra clock edges together tell abort handling apart from the end-of-count stop. The output enables are compared against the expected pin choice before every rising edge.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
    // control register field positions; the port reads them back in place
    localparam int CTRL_LSB_BIT  = 6;
    localparam int CTRL_4W_BIT   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_WR,
        ST_RD,
        ST_DONE
    } xfer_state_t;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic cs_act,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sdi_s
);
    logic [STAGES:0] cs_q;
    logic [STAGES:0] sclk_q;
    logic [STAGES:0] sdi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= '1;
            sclk_q <= '0;
            sdi_q  <= '0;
        end else begin
            cs_q   <= {cs_q[STAGES-1:0], cs_n};
            sclk_q <= {sclk_q[STAGES-1:0], sclk};
            sdi_q  <= {sdi_q[STAGES-1:0], sdi};
        end
    end

    assign cs_act    = ~cs_q[STAGES-1];
    assign sclk_rise = sclk_q[STAGES-1] & ~sclk_q[STAGES];
    assign sclk_fall = ~sclk_q[STAGES-1] & sclk_q[STAGES];
    assign sdi_s     = sdi_q[STAGES-1];
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
    import spi_reg_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int ADDR_W   = 5,
    parameter int BYTE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              lsb_first,
    output logic              four_wire
);
    logic [BYTE_W-1:0] regs [1:NUM_REGS-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lsb_first <= 1'b0;
            four_wire <= 1'b0;
        end else if (wr_en && wr_addr == '0) begin
            lsb_first <= wr_data[CTRL_LSB_BIT];
            four_wire <= wr_data[CTRL_4W_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 1; i < NUM_REGS; i++) regs[i] <= '0;
        end else if (wr_en) begin
            for (int i = 1; i < NUM_REGS; i++)
                if (wr_addr == ADDR_W'(i)) regs[i] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == '0) begin
            rd_data[CTRL_LSB_BIT] = lsb_first;
            rd_data[CTRL_4W_BIT]  = four_wire;
        end
        for (int i = 1; i < NUM_REGS; i++)
            if (rd_addr == ADDR_W'(i)) rd_data = regs[i];
    end

    // R6: a write to register 0 lands in the order bit on the next cycle
    assert_ctrl_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> (lsb_first == $past(wr_data[CTRL_LSB_BIT])
                                      && four_wire == $past(wr_data[CTRL_4W_BIT])));

    // R10: the control bits move only on a register-0 write
    assert_ctrl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == '0) |=> ($stable(lsb_first) && $stable(four_wire)));
endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
    import spi_reg_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sdi,
    input  logic              lsb_first,
    input  logic              four_wire,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              out_bit,
    output logic              sdio_oe,
    output logic              sdo_oe
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam int LEN_W = BYTE_W - 1 - ADDR_W;

    xfer_state_t state, state_nx;

    logic [CNT_W-1:0]  bit_cnt;
    logic [LEN_W-1:0]  len_q, byte_cnt;
    logic [ADDR_W-1:0] addr_q, addr_step;
    logic [BYTE_W-1:0] shin_q, shout_q, byte_nx;
    logic              out_q;
    logic              byte_end, last_byte, hdr_rw;
    logic [LEN_W-1:0]  hdr_len;
    logic [ADDR_W-1:0] hdr_addr;

    // shifting from the far end in LSB-first order lands bits in place
    assign byte_nx   = lsb_first ? {sdi, shin_q[BYTE_W-1:1]} : {shin_q[BYTE_W-2:0], sdi};
    assign byte_end  = sclk_rise && (bit_cnt == CNT_W'(BYTE_W-1));
    assign last_byte = (byte_cnt == len_q);
    assign addr_step = lsb_first ? addr_q - 1'b1 : addr_q + 1'b1;
    assign hdr_rw    = byte_nx[BYTE_W-1];
    assign hdr_len   = byte_nx[BYTE_W-2 -: LEN_W];
    assign hdr_addr  = byte_nx[ADDR_W-1:0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (cs_act) state_nx = ST_HDR;
            ST_HDR:  if (byte_end) state_nx = hdr_rw ? ST_RD : ST_WR;
            ST_WR,
            ST_RD:   if (byte_end && last_byte) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_DONE;
            default: state_nx = ST_IDLE;
        endcase
        if (!cs_act) state_nx = ST_IDLE;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            byte_cnt <= '0;
            len_q    <= '0;
            addr_q   <= '0;
            shin_q   <= '0;
            shout_q  <= '0;
            out_q    <= 1'b0;
        end else if (!cs_act || state == ST_IDLE) begin
            bit_cnt  <= '0;
            byte_cnt <= '0;
            shin_q   <= '0;
        end else begin
            if (sclk_rise && (state == ST_HDR || state == ST_WR || state == ST_RD))
                bit_cnt <= bit_cnt + 1'b1;
            if (sclk_rise && (state == ST_HDR || state == ST_WR))
                shin_q <= byte_nx;
            if (byte_end && state == ST_HDR) begin
                len_q   <= hdr_len;
                addr_q  <= hdr_addr;
                shout_q <= rd_data;
            end
            if (byte_end && (state == ST_WR || state == ST_RD)) begin
                byte_cnt <= byte_cnt + 1'b1;
                addr_q   <= addr_step;
                if (state == ST_RD) shout_q <= rd_data;
            end
            if (sclk_fall && state == ST_RD) begin
                out_q   <= lsb_first ? shout_q[0] : shout_q[BYTE_W-1];
                shout_q <= lsb_first ? (shout_q >> 1) : (shout_q << 1);
            end
        end
    end

    assign rd_addr = (state == ST_HDR) ? hdr_addr : addr_step;
    assign wr_en   = cs_act && (state == ST_WR) && byte_end;
    assign wr_addr = addr_q;
    assign wr_data = byte_nx;

    // outputs
    always_comb begin
        out_bit = out_q;
        sdio_oe = 1'b0;
        sdo_oe  = 1'b0;
        unique case (state)
            ST_RD: begin
                sdio_oe = ~four_wire;
                sdo_oe  = four_wire;
            end
            ST_IDLE, ST_HDR, ST_WR, ST_DONE: ;
            default: ;
        endcase
    end

    // R9: losing chip select empties the transfer and releases both pins
    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (state == ST_IDLE && !sdio_oe && !sdo_oe));

    // R3: a write leaves the counter at a byte boundary
    assert_wr_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (bit_cnt == '0));

    // R8: driving starts only as the command byte completes
    assert_oe_after_hdr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdio_oe || sdo_oe) |-> ($past(state) == ST_HDR));

    // R4: the read bit changes only on a falling serial edge
    assert_out_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_fall && cs_act && state != ST_IDLE) |=> $stable(out_bit));
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import spi_reg_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdio_in,
    output logic sdio_out,
    output logic sdio_oe,
    output logic sdo_out,
    output logic sdo_oe
);
    localparam int ADDR_W = 5;
    localparam int BYTE_W = 8;

    logic              cs_act, sclk_rise, sclk_fall, sdi_s;
    logic              lsb_first, four_wire, wr_en, out_bit;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [BYTE_W-1:0] rd_data, wr_data;

    spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdio_in),
        .cs_act(cs_act), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sdi_s(sdi_s)
    );

    spi_reg_file #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .lsb_first(lsb_first), .four_wire(four_wire)
    );

    spi_xfer_ctrl #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall), .sdi(sdi_s), .lsb_first(lsb_first), .four_wire(four_wire),
        .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .out_bit(out_bit), .sdio_oe(sdio_oe), .sdo_oe(sdo_oe)
    );

    assign sdio_out = out_bit;
    assign sdo_out  = out_bit;

    // R7: at most one pin drives read data
    assert_one_driver_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(sdio_oe && sdo_oe));
endmodule

// File: tb/spi_reg_slave_tb_top.sv
`timescale 1ns/1ps
module spi_reg_slave_tb_top;
    localparam int HALF = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdio_in = 1'b0;
    logic sdio_out, sdio_oe, sdo_out, sdo_oe;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] model [32];
    bit m_lsb = 0, m_four = 0;

    always #2 clk = ~clk;

    spi_reg_slave dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // master: abort_at < 0 runs the full transfer, extra adds clocks after it
    task automatic txn(input bit rw, input int nbytes, input int a, input logic [31:0] wd,
                       input int abort_at, input int extra, output logic [31:0] rd);
        logic [7:0] hdr, b;
        int total, ad;
        bit lsb_now;
        lsb_now = m_lsb;
        rd = '0;
        hdr = {rw, 2'(nbytes - 1), 5'(a)};
        total = 8 + 8 * nbytes;
        cs_n = 1'b0;
        tick(6);
        for (int idx = 0; idx < total + extra; idx++) begin
            int k, j;
            bit in_data;
            if (abort_at >= 0 && idx == abort_at) break;
            k = (idx - 8) / 8;
            j = (idx < 8) ? idx : (idx - 8) % 8;
            b = (idx < 8) ? hdr : ((k < nbytes) ? wd[8*k +: 8] : 8'hA5);
            sdio_in = lsb_now ? b[j] : b[7-j];
            tick(HALF);
            in_data = rw && idx >= 8 && idx < total;
            chk(sdio_oe == (in_data && !m_four), "R8/R7 sdio_oe", 32'(sdio_oe), 32'(in_data && !m_four));
            chk(sdo_oe == (in_data && m_four), "R8/R7 sdo_oe", 32'(sdo_oe), 32'(in_data && m_four));
            if (in_data)
                rd[8*k + (lsb_now ? j : 7 - j)] = m_four ? sdo_out : sdio_out;
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
        end
        tick(HALF);
        cs_n = 1'b1;
        tick(8);
        chk(!sdio_oe && !sdo_oe, "R9 release", {sdio_oe, sdo_oe}, 0);
        if (!rw && abort_at < 0) begin
            for (int q = 0; q < nbytes; q++) begin
                ad = (a + (lsb_now ? -q : q)) & 31;
                if (ad == 0) model[0] = wd[8*q +: 8] & 8'h48;
                else if (ad < 8) model[ad] = wd[8*q +: 8];
            end
            m_lsb  = model[0][6];
            m_four = model[0][3];
        end
        if (rw && abort_at < 0) begin
            for (int q = 0; q < nbytes; q++) begin
                ad = (a + (lsb_now ? -q : q)) & 31;
                chk(rd[8*q +: 8] == model[ad], "R4/R5/R10 read byte", rd[8*q +: 8], model[ad]);
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, wd;
        for (int i = 0; i < 32; i++) model[i] = 8'h00;
        tick(4);
        rst_n = 1'b1;
        tick(4);
        // R1: reset state
        chk(!sdio_oe && !sdo_oe, "R1 enables", {sdio_oe, sdo_oe}, 0);
        txn(1'b1, 1, 0, 0, -1, 0, rd);
        chk(rd[7:0] == 8'h00, "R1 reg0", rd[7:0], 0);
        txn(1'b1, 1, 3, 0, -1, 0, rd);
        chk(rd[7:0] == 8'h00, "R1 reg3", rd[7:0], 0);

        // R2 R3 R5 R6 R7: sweep of order and wire modes
        for (int mode = 0; mode < 4; mode++) begin
            bit lsb, four;
            lsb  = mode[1];
            four = mode[0];
            txn(1'b0, 1, 0, 32'({lsb, 6'b0} | {four, 3'b0} | 8'h25), -1, 0, rd);
            txn(1'b1, 1, 0, 0, -1, 0, rd);
            chk(rd[7:0] == {1'b0, lsb, 2'b0, four, 3'b0}, "R10 reg0 mask", rd[7:0], {1'b0, lsb, 2'b0, four, 3'b0});
            for (int a = 1; a <= 9; a++) begin
                for (int n = 1; n <= 4; n++) begin
                    if (lsb && a - (n - 1) < 1) continue;
                    for (int q = 0; q < 4; q++)
                        wd[8*q +: 8] = 8'((a * 37 + n * 11 + q * 73 + mode * 29) ^ 8'h5A);
                    txn(1'b0, n, a, wd, -1, 0, rd);
                    txn(1'b1, n, a, 0, -1, 0, rd);
                end
            end
        end
        txn(1'b0, 1, 0, 32'h00, -1, 0, rd);

        // R5: read wraps from 31 to 0 then 1
        txn(1'b1, 3, 31, 0, -1, 0, rd);
        chk(rd[7:0] == 8'h00, "R10 out of range reads 0", rd[7:0], 0);

        // R9: write cut after four data bits leaves register 2 untouched
        txn(1'b0, 1, 2, 32'hC3, 12, 0, rd);
        txn(1'b1, 1, 2, 0, -1, 0, rd);
        chk(rd[7:0] == model[2], "R9 partial byte dropped", rd[7:0], model[2]);
        // R9: read cut midway; the enable checks inside cover the release
        txn(1'b1, 2, 3, 0, 12, 0, rd);
        txn(1'b1, 1, 3, 0, -1, 0, rd);

        // R11: extra clocks after the counted byte do not write register 5
        txn(1'b0, 1, 4, 32'h3C, -1, 8, rd);
        txn(1'b1, 2, 4, 0, -1, 0, rd);
        chk(rd[15:8] == model[5], "R11 no extra write", rd[15:8], model[5]);
        // R11: extra clocks after a read produce no drive
        txn(1'b1, 1, 4, 0, -1, 9, rd);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule